// File: doc/BRIEF.md
# Single-Lane Three-Element Structure Loader

This block takes one vector command that loads a single three-element structure into one lane and carries it out. The command names an element width, a packed lane/spacing field, a first destination vector register, a base general-purpose register and an offset register. The block reads three consecutive little-endian elements from memory. Each element goes into the same lane of one of three 64-bit vector registers, and every other lane of those registers keeps its contents. After the loads, the block can post-increment the base register.

The block owns no register storage. It reads and writes an external 32 x 64-bit vector register file through one combinational read port and one write strobe. It reads two general-purpose registers when it accepts a command and writes one back at the end. It issues three memory reads one at a time, using a valid/ready request and a single-cycle response. A command that is malformed, illegal or of the wrong form raises a one-cycle flag and then finishes as a no-op.

Top module: `lane_struct_loader`

## Requirements
- R1: Size code 00, 01 and 10 selects a 1-, 2- or 4-byte element. Size code 11 is not this form. It raises `formFlag` for one cycle and then completes as a no-op.
- R2: For 1-byte elements the lane is lane-field bits [3:1] and the spacing is 1. Bit [0] set marks the command undefined.
- R3: For 2-byte elements the lane is bits [3:2] and the spacing is 2 when bit [1] is 1, otherwise 1. Bit [0] set marks the command undefined.
- R4: For 4-byte elements the lane is bit [3] and the spacing is 2 when bit [2] is 1, otherwise 1. Bits [1:0] nonzero mark the command undefined.
- R5: The destinations are registers d, d+s and d+2s, where d is the 5-bit destination field and s the spacing. They receive the elements at the base address, base+w and base+2w, in that order, where w is the element width. Each element is read little-endian, so the byte at the lowest address is the least significant.
- R6: Each element lands at bit offset lane*w*8 of its register. All other bits of the three registers, and every other register, are unchanged.
- R7: When the offset register number is neither 13 nor 15, the base register becomes base plus the value of the offset register.
- R8: Offset register 13 adds 3*w to the base register. Offset register 15 leaves every general-purpose register unchanged.
- R9: Base register 15, or a third destination number d+2s above 31, makes the command illegal.
- R10: An undefined or illegal command raises `errFlag` for exactly one cycle, then `done`. It makes no memory request and no register write.
- R11: `busy` is high from the cycle after acceptance through the single-cycle `done` pulse. The base register write happens in the `done` cycle.
- R12: Memory reads are issued one at a time. A request stays asserted with a stable address until `memReqReady` is seen.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cmdValid | input | 1 | Command present |
| cmdReady | output | 1 | Block idle, command accepted when valid |
| cmdSize | input | 2 | Element size code |
| cmdLaneSel | input | 4 | Packed lane index / spacing / alignment field |
| cmdDst | input | 5 | First destination vector register |
| cmdBase | input | 4 | Base general-purpose register number |
| cmdOffReg | input | 4 | Offset register number (13 and 15 special) |
| busy | output | 1 | Command in progress |
| done | output | 1 | One-cycle completion pulse |
| errFlag | output | 1 | One-cycle undefined/illegal flag |
| formFlag | output | 1 | One-cycle wrong-form flag |
| gpRdAddrA | output | 4 | GPR read address, base register |
| gpRdDataA | input | 32 | GPR read data, base register |
| gpRdAddrB | output | 4 | GPR read address, offset register |
| gpRdDataB | input | 32 | GPR read data, offset register |
| gpWe | output | 1 | GPR write enable |
| gpWaddr | output | 4 | GPR write address |
| gpWdata | output | 32 | GPR write data |
| vrAddr | output | 5 | Vector register read/write address |
| vrData | input | 64 | Vector register read data |
| vrWe | output | 1 | Vector register write enable |
| vrWdata | output | 64 | Vector register write data |
| memReqValid | output | 1 | Memory read request |
| memReqReady | input | 1 | Memory accepts request |
| memReqAddr | output | 32 | Byte address of request |
| memRspValid | input | 1 | Read response present |
| memRspData | input | 32 | Response bytes, lowest address in bits [7:0] |

## Verification
The hardest case to reach from the ports is a request held across a stall. Three reads go out in sequence, and the bench must show that each address stays put while ready is low. The bench memory drives ready with a pattern that toggles every cycle, so some requests are stalled and others are taken at once. The other hard corner is the boundary between legal and illegal destination numbers. Commands land exactly on register 31 and one step past it, with both spacings. The bench then confirms that the full register file and the GPRs are untouched for the illegal case.

// File: rtl/lane_struct_pkg.sv
package lane_struct_pkg;
  localparam int VEC_W   = 64;
  localparam int VREG_N  = 32;
  localparam int VAW     = $clog2(VREG_N);
  localparam int GPR_W   = 32;
  localparam int GAW     = 4;
  localparam int ADDR_W  = 32;
  localparam int MEM_W   = 32;
  localparam int ELEMS   = 3;
  localparam logic [GAW-1:0] REG_PC  = 4'd15;
  localparam logic [GAW-1:0] REG_IMM = 4'd13;

  typedef struct packed {
    logic [2:0] ebytes;
    logic [2:0] lane;
    logic [1:0] spacing;
    logic       wrongForm;
    logic       undef;
    logic       illegal;
    logic       wback;
    logic       useIdxReg;
  } decode_t;

  typedef struct packed {
    logic       latchCmd;
    logic       capElem;
    logic       wrVec;
    logic       wrBase;
    logic [1:0] elemSel;
  } strobe_t;

  function automatic decode_t decodeCmd(input logic [1:0] size, input logic [3:0] sel,
                                        input logic [VAW-1:0] dst, input logic [GAW-1:0] rn,
                                        input logic [GAW-1:0] rm);
    decode_t r;
    logic [VAW:0] last;
    r = '0;
    case (size)
      2'b00: begin r.ebytes = 3'd1; r.lane = sel[3:1];        r.spacing = 2'd1;
                   r.undef = sel[0]; end
      2'b01: begin r.ebytes = 3'd2; r.lane = {1'b0, sel[3:2]}; r.spacing = sel[1] ? 2'd2 : 2'd1;
                   r.undef = sel[0]; end
      2'b10: begin r.ebytes = 3'd4; r.lane = {2'b00, sel[3]}; r.spacing = sel[2] ? 2'd2 : 2'd1;
                   r.undef = |sel[1:0]; end
      default: begin r.ebytes = 3'd1; r.wrongForm = 1'b1; end
    endcase
    last = {1'b0, dst} + {{(VAW-2){1'b0}}, r.spacing, 1'b0};
    r.illegal   = !r.wrongForm && ((rn == REG_PC) || (last > (VAW+1)'(VREG_N-1)));
    r.undef     = r.undef && !r.wrongForm;
    r.wback     = (rm != REG_PC);
    r.useIdxReg = (rm != REG_PC) && (rm != REG_IMM);
    return r;
  endfunction
endpackage

// File: rtl/lane_struct_ctrl.sv
module lane_struct_ctrl
  import lane_struct_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  logic    cmdValid,
  input  logic    decForm,
  input  logic    decBad,
  input  logic    decWback,
  input  logic    memReqReady,
  input  logic    memRspValid,
  output logic    cmdReady,
  output logic    busy,
  output logic    done,
  output logic    errFlag,
  output logic    formFlag,
  output logic    memReqValid,
  output strobe_t strobes
);
  typedef enum logic [2:0] {S_IDLE, S_ERR, S_REQ, S_WAIT, S_WRITE, S_FIN} state_t;
  state_t state;
  logic [1:0] cnt;
  logic okQ, wbackQ, formQ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state <= S_IDLE; cnt <= '0; okQ <= 1'b0; wbackQ <= 1'b0; formQ <= 1'b0;
    end else begin
      case (state)
        S_IDLE: if (cmdValid) begin
          cnt    <= '0;
          formQ  <= decForm;
          okQ    <= !(decForm || decBad);
          wbackQ <= decWback;
          state  <= (decForm || decBad) ? S_ERR : S_REQ;
        end
        S_ERR:   state <= S_FIN;
        S_REQ:   if (memReqReady) state <= S_WAIT;
        S_WAIT:  if (memRspValid) state <= S_WRITE;
        S_WRITE: begin
          if (cnt == 2'(ELEMS-1)) state <= S_FIN;
          else begin cnt <= cnt + 2'd1; state <= S_REQ; end
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  always_comb begin
    cmdReady        = (state == S_IDLE);
    busy            = (state != S_IDLE);
    done            = (state == S_FIN);
    errFlag         = (state == S_ERR) && !formQ;
    formFlag        = (state == S_ERR) && formQ;
    memReqValid     = (state == S_REQ);
    strobes.latchCmd = (state == S_IDLE) && cmdValid;
    strobes.capElem  = (state == S_WAIT) && memRspValid;
    strobes.wrVec    = (state == S_WRITE);
    strobes.wrBase   = (state == S_FIN) && okQ && wbackQ;
    strobes.elemSel  = cnt;
  end

  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rstN) done |=> !done); // R11
  AST_DONE_INSIDE_BUSY: assert property (@(posedge clk) disable iff (!rstN) done |-> busy); // R11
  AST_FLAG_THEN_NOOP_DONE: assert property (@(posedge clk) disable iff (!rstN)
    (errFlag || formFlag) |=> done && !strobes.wrBase && !strobes.wrVec && !memReqValid); // R10
  AST_REQ_HELD: assert property (@(posedge clk) disable iff (!rstN)
    (memReqValid && !memReqReady) |=> memReqValid); // R12
endmodule

// File: rtl/lane_struct_dp.sv
module lane_struct_dp
  import lane_struct_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           strobes,
  input  logic [2:0]        decEbytes,
  input  logic [2:0]        decLane,
  input  logic [1:0]        decSpacing,
  input  logic              decUseIdx,
  input  logic [VAW-1:0]    cmdDst,
  input  logic [GAW-1:0]    cmdBase,
  input  logic [GPR_W-1:0]  baseVal,
  input  logic [GPR_W-1:0]  offVal,
  input  logic [MEM_W-1:0]  memRspData,
  input  logic [VEC_W-1:0]  vrData,
  output logic [ADDR_W-1:0] memReqAddr,
  output logic [VAW-1:0]    vrAddr,
  output logic              vrWe,
  output logic [VEC_W-1:0]  vrWdata,
  output logic              gpWe,
  output logic [GAW-1:0]    gpWaddr,
  output logic [GPR_W-1:0]  gpWdata
);
  logic [2:0]       ebQ, laneQ;
  logic [1:0]       spQ;
  logic             useIdxQ;
  logic [VAW-1:0]   dstQ;
  logic [GAW-1:0]   rnQ;
  logic [GPR_W-1:0] baseQ, offQ;
  logic [MEM_W-1:0] elemQ;
  logic [MEM_W-1:0] widthMask;
  logic [5:0]       bitOff;
  logic [VEC_W-1:0] laneMask;

  always_comb begin
    case (ebQ)
      3'd1:    widthMask = 32'h0000_00FF;
      3'd2:    widthMask = 32'h0000_FFFF;
      default: widthMask = 32'hFFFF_FFFF;
    endcase
    bitOff = (6'(laneQ) * 6'(ebQ)) << 3;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      ebQ <= 3'd1; laneQ <= '0; spQ <= 2'd1; useIdxQ <= 1'b0;
      dstQ <= '0; rnQ <= '0; baseQ <= '0; offQ <= '0; elemQ <= '0;
    end else begin
      if (strobes.latchCmd) begin
        ebQ <= decEbytes; laneQ <= decLane; spQ <= decSpacing; useIdxQ <= decUseIdx;
        dstQ <= cmdDst; rnQ <= cmdBase; baseQ <= baseVal; offQ <= offVal;
      end
      if (strobes.capElem) elemQ <= memRspData & widthMask;
    end
  end

  assign memReqAddr = baseQ + ADDR_W'(strobes.elemSel) * ADDR_W'(ebQ);
  assign vrAddr     = dstQ + VAW'(strobes.elemSel) * VAW'(spQ);
  assign laneMask   = {{(VEC_W-MEM_W){1'b0}}, widthMask} << bitOff;
  assign vrWe       = strobes.wrVec;
  assign vrWdata    = (vrData & ~laneMask) | ({{(VEC_W-MEM_W){1'b0}}, elemQ} << bitOff);
  assign gpWe       = strobes.wrBase;
  assign gpWaddr    = rnQ;
  assign gpWdata    = useIdxQ ? (baseQ + offQ) : (baseQ + GPR_W'(3) * GPR_W'(ebQ));

  AST_ELEM_FITS_WIDTH: assert property (@(posedge clk) disable iff (!rstN)
    vrWe |-> ((elemQ & ~widthMask) == '0)); // R6
endmodule

// File: rtl/lane_struct_loader.sv
module lane_struct_loader
  import lane_struct_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              cmdValid,
  output logic              cmdReady,
  input  logic [1:0]        cmdSize,
  input  logic [3:0]        cmdLaneSel,
  input  logic [VAW-1:0]    cmdDst,
  input  logic [GAW-1:0]    cmdBase,
  input  logic [GAW-1:0]    cmdOffReg,
  output logic              busy,
  output logic              done,
  output logic              errFlag,
  output logic              formFlag,
  output logic [GAW-1:0]    gpRdAddrA,
  input  logic [GPR_W-1:0]  gpRdDataA,
  output logic [GAW-1:0]    gpRdAddrB,
  input  logic [GPR_W-1:0]  gpRdDataB,
  output logic              gpWe,
  output logic [GAW-1:0]    gpWaddr,
  output logic [GPR_W-1:0]  gpWdata,
  output logic [VAW-1:0]    vrAddr,
  input  logic [VEC_W-1:0]  vrData,
  output logic              vrWe,
  output logic [VEC_W-1:0]  vrWdata,
  output logic              memReqValid,
  input  logic              memReqReady,
  output logic [ADDR_W-1:0] memReqAddr,
  input  logic              memRspValid,
  input  logic [MEM_W-1:0]  memRspData
);
  decode_t dec;
  strobe_t strobes;

  assign dec       = decodeCmd(cmdSize, cmdLaneSel, cmdDst, cmdBase, cmdOffReg);
  assign gpRdAddrA = cmdBase;
  assign gpRdAddrB = cmdOffReg;

  lane_struct_ctrl ctrl (
    .clk(clk), .rstN(rstN), .cmdValid(cmdValid),
    .decForm(dec.wrongForm), .decBad(dec.undef || dec.illegal), .decWback(dec.wback),
    .memReqReady(memReqReady), .memRspValid(memRspValid),
    .cmdReady(cmdReady), .busy(busy), .done(done), .errFlag(errFlag), .formFlag(formFlag),
    .memReqValid(memReqValid), .strobes(strobes)
  );

  lane_struct_dp dp (
    .clk(clk), .rstN(rstN), .strobes(strobes),
    .decEbytes(dec.ebytes), .decLane(dec.lane), .decSpacing(dec.spacing), .decUseIdx(dec.useIdxReg),
    .cmdDst(cmdDst), .cmdBase(cmdBase), .baseVal(gpRdDataA), .offVal(gpRdDataB),
    .memRspData(memRspData), .vrData(vrData),
    .memReqAddr(memReqAddr), .vrAddr(vrAddr), .vrWe(vrWe), .vrWdata(vrWdata),
    .gpWe(gpWe), .gpWaddr(gpWaddr), .gpWdata(gpWdata)
  );

  AST_ADDR_STABLE_STALL: assert property (@(posedge clk) disable iff (!rstN)
    (memReqValid && !memReqReady) |=> $stable(memReqAddr)); // R12
  AST_BASE_WRITE_AT_DONE: assert property (@(posedge clk) disable iff (!rstN)
    gpWe |-> done); // R11
  AST_NO_VEC_WRITE_WITH_REQ: assert property (@(posedge clk) disable iff (!rstN)
    vrWe |-> !memReqValid); // R12
endmodule

// File: tb/lane_struct_loader_test.sv
module lane_struct_loader_test;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  always #2.5 clk = ~clk;

  logic cmdValid = 1'b0, cmdReady;
  logic [1:0] cmdSize = '0;
  logic [3:0] cmdLaneSel = '0;
  logic [4:0] cmdDst = '0;
  logic [3:0] cmdBase = '0, cmdOffReg = '0;
  logic busy, done, errFlag, formFlag;
  logic [3:0] gpRdAddrA, gpRdAddrB, gpWaddr;
  logic [31:0] gpRdDataA, gpRdDataB, gpWdata;
  logic gpWe;
  logic [4:0] vrAddr;
  logic [63:0] vrData, vrWdata;
  logic vrWe;
  logic memReqValid, memReqReady, memRspValid;
  logic [31:0] memReqAddr, memRspData;

  logic [63:0] vreg [32];
  logic [31:0] gpr [16];
  logic rdyTog;
  int nMemHs, nVecWr, nGpWr, nErr, nForm;
  int total = 0, bad = 0;

  lane_struct_loader uut (.*);

  function automatic logic [7:0] memByte(input logic [31:0] a);
    return 8'(a * 13 + 7) ^ a[15:8];
  endfunction

  assign vrData      = vreg[vrAddr];
  assign gpRdDataA   = gpr[gpRdAddrA];
  assign gpRdDataB   = gpr[gpRdAddrB];
  assign memReqReady = rdyTog;

  always @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < 32; i++) vreg[i] <= 64'h0123_4567_89AB_CDEF ^ (64'(i) * 64'h0101_0101_0101_0101);
      for (int i = 0; i < 16; i++) gpr[i] <= 32'h1000 + 32'(i) * 32'h100;
      rdyTog <= 1'b0; memRspValid <= 1'b0; memRspData <= '0;
      nMemHs <= 0; nVecWr <= 0; nGpWr <= 0; nErr <= 0; nForm <= 0;
    end else begin
      rdyTog <= ~rdyTog;
      if (vrWe) begin vreg[vrAddr] <= vrWdata; nVecWr <= nVecWr + 1; end
      if (gpWe) begin gpr[gpWaddr] <= gpWdata; nGpWr <= nGpWr + 1; end
      if (errFlag) nErr <= nErr + 1;
      if (formFlag) nForm <= nForm + 1;
      memRspValid <= memReqValid && memReqReady;
      if (memReqValid && memReqReady) begin
        nMemHs <= nMemHs + 1;
        memRspData <= {memByte(memReqAddr + 3), memByte(memReqAddr + 2),
                       memByte(memReqAddr + 1), memByte(memReqAddr)};
      end
    end
  end

  task automatic chk(input logic ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // kind: 0 legal, 1 undefined/illegal, 2 wrong form
  task automatic runCmd(input logic [1:0] sz, input logic [3:0] sel, input logic [4:0] d,
                        input logic [3:0] rn, input logic [3:0] rm, input int kind, input string tag);
    logic [63:0] sv [32];
    logic [31:0] sg [16];
    logic [63:0] ev [32];
    logic [31:0] eg [16];
    int eb, lane, sp, m0, v0, g0, e0, f0, waited;
    logic sawGpWe;
    for (int i = 0; i < 32; i++) sv[i] = vreg[i];
    for (int i = 0; i < 16; i++) sg[i] = gpr[i];
    m0 = nMemHs; v0 = nVecWr; g0 = nGpWr; e0 = nErr; f0 = nForm;
    @(negedge clk);
    chk(cmdReady == 1'b1, {tag, " R11 ready idle"}, 64'(cmdReady), 64'd1);
    cmdValid = 1'b1; cmdSize = sz; cmdLaneSel = sel; cmdDst = d; cmdBase = rn; cmdOffReg = rm;
    @(negedge clk);
    cmdValid = 1'b0;
    chk(busy == 1'b1, {tag, " R11 busy after accept"}, 64'(busy), 64'd1);
    waited = 0;
    while (!done && waited < 60) begin @(negedge clk); waited++; end
    chk(done && busy, {tag, " R11 done within busy"}, 64'({done, busy}), 64'd3);
    sawGpWe = gpWe;
    @(negedge clk);
    chk(!done && !busy, {tag, " R11 done one cycle"}, 64'({done, busy}), 64'd0);
    eb = 1 << sz;
    lane = (sz == 0) ? int'(sel[3:1]) : (sz == 1) ? int'(sel[3:2]) : int'(sel[3]);
    sp = (sz == 0) ? 1 : (sz == 1) ? (sel[1] ? 2 : 1) : (sel[2] ? 2 : 1);
    for (int i = 0; i < 32; i++) ev[i] = sv[i];
    for (int i = 0; i < 16; i++) eg[i] = sg[i];
    if (kind == 0) begin
      for (int k = 0; k < 3; k++) begin
        logic [63:0] el, mk;
        el = '0;
        for (int b = 0; b < eb; b++) el[8*b +: 8] = memByte(sg[rn] + 32'(k * eb + b));
        mk = ((64'd1 << (8 * eb)) - 1) << (lane * eb * 8);
        ev[d + k * sp] = (sv[d + k * sp] & ~mk) | (el << (lane * eb * 8));
      end
      if (rm == 4'd13) eg[rn] = sg[rn] + 32'(3 * eb);
      else if (rm != 4'd15) eg[rn] = sg[rn] + sg[rm];
      chk(nMemHs - m0 == 3, {tag, " R12 three reads"}, 64'(nMemHs - m0), 64'd3);
      chk(sawGpWe == (rm != 4'd15), {tag, " R11 base write in done cycle"}, 64'(sawGpWe), 64'(rm != 4'd15));
      for (int k = 0; k < 3; k++)
        chk(vreg[d + k * sp] === ev[d + k * sp], {tag, " R5 R6 destination"}, vreg[d + k * sp], ev[d + k * sp]);
    end else begin
      chk((nMemHs == m0) && (nVecWr == v0) && (nGpWr == g0), {tag, " R10 no side effects"},
          64'((nMemHs - m0) + (nVecWr - v0) + (nGpWr - g0)), 64'd0);
      if (kind == 1) chk(nErr - e0 == 1 && nForm == f0, {tag, " R10 err one cycle"}, 64'(nErr - e0), 64'd1);
      else chk(nForm - f0 == 1 && nErr == e0, {tag, " R1 form flag one cycle"}, 64'(nForm - f0), 64'd1);
    end
    begin
      int badV = 0, badG = 0;
      for (int i = 0; i < 32; i++) if (vreg[i] !== ev[i]) badV++;
      for (int i = 0; i < 16; i++) if (gpr[i] !== eg[i]) badG++;
      chk(badV == 0, {tag, " R6 register file intact"}, 64'(badV), 64'd0);
      chk(badG == 0, {tag, " R7 R8 GPR contents"}, 64'(badG), 64'd0);
    end
  endtask

  task automatic testReset();
    @(negedge clk);
    chk(!busy && !done && !errFlag && !formFlag && !memReqValid && !vrWe && !gpWe,
        "R11 reset state", 64'({busy, done, errFlag, formFlag, memReqValid, vrWe, gpWe}), 64'd0);
  endtask

  task automatic testByte();      runCmd(2'b00, 4'b1010, 5'd3,  4'd2, 4'd13, 0, "R2 byte lane5 imm"); endtask
  task automatic testByteTop();   runCmd(2'b00, 4'b1110, 5'd29, 4'd1, 4'd15, 0, "R2 R9 byte lane7 to r31"); endtask
  task automatic testHalfSp2();   runCmd(2'b01, 4'b1110, 5'd10, 4'd1, 4'd4,  0, "R3 R7 half lane3 sp2 idxreg"); endtask
  task automatic testHalfSp1();   runCmd(2'b01, 4'b0100, 5'd0,  4'd3, 4'd13, 0, "R3 R8 half lane1 sp1"); endtask
  task automatic testWordSp1();   runCmd(2'b10, 4'b1000, 5'd29, 4'd5, 4'd15, 0, "R4 R8 word lane1 no wb"); endtask
  task automatic testWordSp2();   runCmd(2'b10, 4'b0100, 5'd20, 4'd6, 4'd13, 0, "R4 R5 word lane0 sp2"); endtask
  task automatic testUndefByte(); runCmd(2'b00, 4'b0011, 5'd2,  4'd2, 4'd13, 1, "R2 R10 byte undef"); endtask
  task automatic testUndefHalf(); runCmd(2'b01, 4'b1001, 5'd2,  4'd2, 4'd4,  1, "R3 R10 half undef"); endtask
  task automatic testUndefWord(); runCmd(2'b10, 4'b1010, 5'd2,  4'd2, 4'd13, 1, "R4 R10 word undef"); endtask
  task automatic testWrongForm(); runCmd(2'b11, 4'b0000, 5'd2,  4'd2, 4'd13, 2, "R1 size 11"); endtask
  task automatic testBasePc();    runCmd(2'b00, 4'b0000, 5'd4,  4'd15, 4'd13, 1, "R9 R10 base 15"); endtask
  task automatic testPastTop();   runCmd(2'b10, 4'b0100, 5'd28, 4'd2, 4'd13, 1, "R9 word sp2 past r31"); endtask
  task automatic testPastTopB();  runCmd(2'b00, 4'b0000, 5'd30, 4'd2, 4'd4,  1, "R9 byte past r31"); endtask

  initial begin
    repeat (200000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog expired actual=hung expected=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk); rstN = 1'b1;
    testReset();
    testByte();
    testByteTop();
    testHalfSp2();
    testHalfSp1();
    testWordSp1();
    testWordSp2();
    testUndefByte();
    testUndefHalf();
    testUndefWord();
    testWrongForm();
    testBasePc();
    testPastTop();
    testPastTopB();
    testByte();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule